// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Byte Receiver

This block recovers 8-bit characters from an asynchronous serial line. It runs on the system clock. A one-cycle enable pulse, `tick_en`, arrives sixteen times per bit period and paces every decision the receiver makes. The serial input first passes through a flop synchronizer. The receiver then watches for a high-to-low change at tick rate. Eight ticks after that change it looks at the line again, and if the line has gone back high it treats the event as noise and returns to waiting.

Once a start is confirmed, the receiver samples the line once per bit period, sixteen ticks apart. Each sample falls near the middle of a bit. The eight data bits are shifted in least-significant first, and then the stop bit is checked. At the end of every character the byte is copied into an output register and a ready flag is raised. When the stop bit was low, an error flag is raised as well. Both flags stay up, and the byte stays unchanged, until the receiver accepts the falling edge of the next start bit.

Top module: `serial_byte_receiver`

## Requirements
- R1: While `rst_n` is low, `rx_byte` is 0 and `byte_ready` and `frame_err` are 0.
- R2: If the line stays high (the idle level), no output changes.
- R3: A low pulse that has ended by the eighth tick after the detected edge is discarded. No character is produced and `rx_byte` keeps its value.
- R4: Data bits are taken least-significant first. The first data bit sampled appears in bit 0 of `rx_byte`.
- R5: The start bit is re-checked 8 ticks after the tick at which the edge was seen. Each data bit and the stop bit is sampled 16 ticks after the sample before it.
- R6: One clock after the tick that samples the stop bit, `byte_ready` goes to 1 and `rx_byte` holds the character. With a high stop bit, `frame_err` is 0.
- R7: With a low stop bit, both `byte_ready` and `frame_err` go to 1. `frame_err` is never 1 while `byte_ready` is 0.
- R8: `byte_ready`, `frame_err` and `rx_byte` hold their values until a falling edge is accepted in idle. On the clock after that edge, both flags clear.
- R9: While `tick_en` is low, nothing advances. A line that goes low and then returns high between two ticks is not seen as an edge.
- R10: The line passes through two synchronizing flops. A level driven just after one clock edge first affects the flags on the third rising edge, provided `tick_en` is high on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Sample enable, 16 pulses per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_byte | output | 8 | Last received character |
| byte_ready | output | 1 | A character has been received |
| frame_err | output | 1 | The last character had a low stop bit |

## Verification
Every result has a fixed delay from its cause. A line change reaches the edge detector two clocks after it is driven. The edge is acted on at the next tick, and the flags clear one clock after that tick. The new byte and the flags appear one clock after the tick that falls 152 ticks after the edge tick. The bench runs a behavioural model that counts ticks from the edge, and compares it with all three outputs at every falling clock edge, half a cycle after the registers update. Directed checks probe the synchronizer delay clock by clock, and test tick gating with `tick_en` held low.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

endpackage

// File: rtl/rxs_line_sync.sv
// Synchronizer chain plus tick-rate falling-edge detection.
module rxs_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic line_raw,
  output logic line_q,
  output logic fall_tick
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   last_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b1;
        else        chain_q[s] <= line_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b1;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign line_q = chain_q[SYNC_STAGES-1];

  // level seen at the previous tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= 1'b1;
    else if (tick_en) last_q <= line_q;
  end

  assign fall_tick = tick_en & last_q & ~line_q;

endmodule

// File: rtl/rxs_tick_timer.sv
// Tick counter within a bit period and data bit index.
module rxs_tick_timer #(
  parameter int OSR   = 16,
  parameter int NBITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic cnt_clr,
  input  logic bit_clr,
  input  logic bit_inc,
  output logic half_hit,
  output logic full_hit,
  output logic last_bit
);

  localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int BW = (NBITS > 2) ? $clog2(NBITS) : 1;
  localparam logic [CW-1:0] CNT_TOP  = CW'(OSR - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(OSR / 2 - 1);
  localparam logic [BW-1:0] BIT_TOP  = BW'(NBITS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bit_q, bit_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_clr)      cnt_d = '0;
    else if (tick_en) cnt_d = (cnt_q == CNT_TOP) ? '0 : cnt_q + CW'(1);
  end

  always_comb begin
    bit_d = bit_q;
    if (bit_clr)      bit_d = '0;
    else if (bit_inc) bit_d = bit_q + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bit_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      bit_q <= bit_d;
    end
  end

  assign half_hit = tick_en && (cnt_q == CNT_HALF);
  assign full_hit = tick_en && (cnt_q == CNT_TOP);
  assign last_bit = (bit_q == BIT_TOP);

endmodule

// File: rtl/rxs_ctrl.sv
// Receive sequencer and status flags.
module rxs_ctrl
  import serial_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fall_tick,
  input  logic      line_q,
  input  logic      half_hit,
  input  logic      full_hit,
  input  logic      last_bit,
  output logic      cnt_clr,
  output logic      bit_clr,
  output logic      shift_en,
  output logic      load_out,
  output logic      ready_q,
  output logic      ferr_q,
  output rx_state_e state_o
);

  rx_state_e state_q, state_d;
  logic      flag_clr;
  logic      ready_d, ferr_d;

  always_comb begin
    state_d  = state_q;
    cnt_clr  = 1'b0;
    bit_clr  = 1'b0;
    shift_en = 1'b0;
    load_out = 1'b0;
    flag_clr = 1'b0;
    case (state_q)
      RX_IDLE: begin
        cnt_clr = 1'b1;
        if (fall_tick) begin
          state_d  = RX_START;
          flag_clr = 1'b1;
        end
      end
      RX_START: begin
        if (half_hit) begin
          if (!line_q) begin
            state_d = RX_DATA;
            cnt_clr = 1'b1;
            bit_clr = 1'b1;
          end else begin
            state_d = RX_IDLE;
          end
        end
      end
      RX_DATA: begin
        if (full_hit) begin
          shift_en = 1'b1;
          if (last_bit) state_d = RX_STOP;
        end
      end
      RX_STOP: begin
        if (full_hit) begin
          load_out = 1'b1;
          state_d  = RX_IDLE;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_comb begin
    ready_d = ready_q;
    ferr_d  = ferr_q;
    if (flag_clr) begin
      ready_d = 1'b0;
      ferr_d  = 1'b0;
    end else if (load_out) begin
      ready_d = 1'b1;
      ferr_d  = ~line_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      ready_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= ready_d;
      ferr_q  <= ferr_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/rxs_shifter.sv
// LSB-first shift register and output holding register.
module rxs_shifter #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             load_out,
  input  logic             line_q,
  output logic [NBITS-1:0] byte_o
);

  logic [NBITS-1:0] sr_q, sr_d;
  logic [NBITS-1:0] hold_q, hold_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {line_q, sr_q[NBITS-1:1]};
  end

  always_comb begin
    hold_d = hold_q;
    if (load_out) hold_d = sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      hold_q <= '0;
    end else begin
      sr_q   <= sr_d;
      hold_q <= hold_d;
    end
  end

  assign byte_o = hold_q;

endmodule

// File: rtl/serial_byte_receiver.sv
module serial_byte_receiver
  import serial_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int NBITS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             rx_line,
  output logic [NBITS-1:0] rx_byte,
  output logic             byte_ready,
  output logic             frame_err
);

  logic      line_w, fall_w;
  logic      half_w, full_w, last_w;
  logic      cnt_clr_w, bit_clr_w, shift_w, load_w;
  rx_state_e state_w;

  rxs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .line_raw  (rx_line),
    .line_q    (line_w),
    .fall_tick (fall_w)
  );

  rxs_tick_timer #(.OSR(OSR), .NBITS(NBITS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .cnt_clr  (cnt_clr_w),
    .bit_clr  (bit_clr_w),
    .bit_inc  (shift_w),
    .half_hit (half_w),
    .full_hit (full_w),
    .last_bit (last_w)
  );

  rxs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_tick (fall_w),
    .line_q    (line_w),
    .half_hit  (half_w),
    .full_hit  (full_w),
    .last_bit  (last_w),
    .cnt_clr   (cnt_clr_w),
    .bit_clr   (bit_clr_w),
    .shift_en  (shift_w),
    .load_out  (load_w),
    .ready_q   (byte_ready),
    .ferr_q    (frame_err),
    .state_o   (state_w)
  );

  rxs_shifter #(.NBITS(NBITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_w),
    .load_out (load_w),
    .line_q   (line_w),
    .byte_o   (rx_byte)
  );

endmodule

// File: rtl/serial_byte_receiver_chk.sv
module serial_byte_receiver_chk
  import serial_rx_pkg::*;
#(
  parameter int NBITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [NBITS-1:0] rx_byte,
  input logic             byte_ready,
  input logic             frame_err,
  input rx_state_e        state,
  input logic             fall_tick
);

  a_r7_err_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> byte_ready);

  a_r8_clear_only_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(byte_ready) |-> $past(fall_tick && state == RX_IDLE));

  a_r8_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ready && $past(byte_ready)) |-> $stable(rx_byte));

  a_r9_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(state) && $stable(byte_ready) && $stable(frame_err)));

  a_r6_ready_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_ready) |-> $past(state == RX_STOP));

endmodule

bind serial_byte_receiver serial_byte_receiver_chk #(.NBITS(NBITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .rx_byte    (rx_byte),
  .byte_ready (byte_ready),
  .frame_err  (frame_err),
  .state      (state_w),
  .fall_tick  (fall_w)
);

// File: tb/serial_byte_receiver_test.sv
`timescale 1ns/1ps
module serial_byte_receiver_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       rx_line = 1'b1;
  logic [7:0] rx_byte;
  logic       byte_ready, frame_err;

  int  checks = 0;
  int  failures = 0;
  int  div = 1;
  int  phase = 0;
  bit  tick_off = 1'b0;

  // reference model state
  logic       m_s1, m_s2, m_last;
  int         m_k;
  logic [7:0] m_sr, m_byte;
  logic       m_rdy, m_fe;

  serial_byte_receiver uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .rx_line    (rx_line),
    .rx_byte    (rx_byte),
    .byte_ready (byte_ready),
    .frame_err  (frame_err)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (tick_off) tick_en <= 1'b0;
    else begin
      tick_en <= (phase == 0);
      phase = (phase + 1) % div;
    end
  end

  // model: counts ticks since the accepted edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_last = 1; m_k = -1;
      m_sr = 0; m_byte = 0; m_rdy = 0; m_fe = 0;
    end else begin
      if (tick_en) begin
        if (m_k < 0) begin
          if (m_last && !m_s2) begin
            m_k = 0; m_rdy = 0; m_fe = 0;
          end
        end else begin
          m_k = m_k + 1;
          if (m_k == 8) begin
            if (m_s2) m_k = -1;
          end else if (m_k > 8 && m_k < 152 && ((m_k - 8) % 16) == 0) begin
            m_sr[(m_k - 8) / 16 - 1] = m_s2;
          end else if (m_k == 152) begin
            m_byte = m_sr; m_rdy = 1; m_fe = !m_s2; m_k = -1;
          end
        end
        m_last = m_s2;
      end
      m_s2 = m_s1;
      m_s1 = rx_line;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 model byte", rx_byte, m_byte);
      check("R6 model ready", byte_ready, m_rdy);
      check("R7 model ferr", frame_err, m_fe);
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n * div) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_v);
    rx_line = 1'b0; wait_ticks(16);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i]; wait_ticks(16);
    end
    rx_line = stop_v; wait_ticks(16);
    rx_line = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset byte", rx_byte, 8'h00);
    check("R1 reset ready", byte_ready, 1'b0);
    check("R1 reset ferr", frame_err, 1'b0);
    rst_n = 1'b1;

    wait_ticks(40);
    check("R2 idle ready", byte_ready, 1'b0);
    check("R2 idle byte", rx_byte, 8'h00);

    send_frame(8'hA5, 1'b1); wait_ticks(8);
    check("R4 byte A5", rx_byte, 8'hA5);
    check("R6 ready A5", byte_ready, 1'b1);
    check("R6 ferr A5", frame_err, 1'b0);

    send_frame(8'h3C, 1'b1); wait_ticks(8);
    check("R4 byte 3C", rx_byte, 8'h3C);
    check("R5 ready 3C", byte_ready, 1'b1);

    wait_ticks(100);
    check("R8 ready held", byte_ready, 1'b1);
    check("R8 byte held", rx_byte, 8'h3C);

    // synchronizer delay, then a false start
    @(negedge clk); rx_line = 1'b0;
    @(negedge clk); check("R10 after edge 1", byte_ready, 1'b1);
    @(negedge clk); check("R10 after edge 2", byte_ready, 1'b1);
    @(negedge clk); check("R10 after edge 3", byte_ready, 1'b0);
    wait_ticks(3); rx_line = 1'b1;
    wait_ticks(30);
    check("R3 no char ready", byte_ready, 1'b0);
    check("R3 byte kept", rx_byte, 8'h3C);

    send_frame(8'h81, 1'b0); wait_ticks(8);
    check("R7 bad stop ready", byte_ready, 1'b1);
    check("R7 bad stop ferr", frame_err, 1'b1);
    check("R7 bad stop byte", rx_byte, 8'h81);
    wait_ticks(16);

    send_frame(8'hFF, 1'b1); wait_ticks(8);
    check("R7 ferr cleared", frame_err, 1'b0);
    check("R4 byte FF", rx_byte, 8'hFF);
    send_frame(8'h00, 1'b1); wait_ticks(8);
    check("R4 byte 00", rx_byte, 8'h00);

    div = 3; wait_ticks(4);
    send_frame(8'h5A, 1'b1); wait_ticks(8);
    check("R5 slow ticks byte", rx_byte, 8'h5A);
    check("R5 slow ticks ready", byte_ready, 1'b1);

    // low pulse entirely between ticks
    @(negedge clk); tick_off = 1'b1;
    repeat (3) @(negedge clk);
    rx_line = 1'b0;
    repeat (50) @(negedge clk);
    check("R9 frozen ready", byte_ready, 1'b1);
    rx_line = 1'b1;
    repeat (10) @(negedge clk);
    tick_off = 1'b0;
    wait_ticks(20);
    check("R9 no edge ready", byte_ready, 1'b1);
    check("R9 no edge byte", rx_byte, 8'h5A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule